// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a real-time clock core on a 32-bit word-addressed register bus. It turns a stream of slow-clock tick pulses into whole seconds: a prescaler counts tick pulses and, while the run bit is set, advances a 32-bit seconds counter once per full prescaler period. Software can preload the counter at any time and read the current time from a separate read-only register.

One alarm compare register raises a sticky status flag on the counter step that lands on the alarm value, provided the alarm-enable bit is set. The status flag is cleared by a write-one-to-clear register. A mask bit decides whether the flag reaches the interrupt output. A build parameter selects Gray-coded storage. In that build, values written to the preload and alarm registers are Gray words, and both the live time and the alarm read back as Gray words.

The bus is a single-cycle interface. A write is captured on the rising clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The word select comes from address bits [4:2]: 0x00 control, 0x04 preload, 0x08 alarm, 0x0C mask, 0x10 clear, 0x14 status, 0x18 live time.

Top module: `rtc_seconds_core`

## Requirements
- R1: A synchronous reset leaves control at 0, the counter at 0, the alarm at 0, the mask bit at 1, the status bit at 0, and `irq` low.
- R2: While control bit 1 (run) is 1, the counter rises by exactly one on every 2^PRESC_W-th `rtc_tick` pulse. While run is 0, ticks change neither the counter nor the prescaler phase.
- R3: A write to 0x04 loads the counter and restarts the prescaler phase at zero. It takes priority over a counter step in the same cycle.
- R4: 0x18 reads the current count. The counter wraps from 0xFFFFFFFF to 0.
- R5: With GRAY_STORE=1, a preload word is taken as Gray code and decoded into the count. 0x18 returns count ^ (count >> 1), and the alarm register reads back exactly as written.
- R6: Status bit 0 (register 0x14) is set on a counter step whose new value, in the stored coding, equals the alarm word. This happens only while control bit 0 (alarm enable) is 1. An alarm word of 0 never matches.
- R7: Writing 0x10 with bit 0 = 1 clears the status bit, and a same-cycle set wins over the clear. A write with bit 0 = 0 leaves the status unchanged.
- R8: `irq` equals the status bit AND NOT mask bit 0 (register 0x0C). The mask does not stop the status bit from being set.
- R9: Readback: control returns bits [1:0] only, mask returns bit 0 only, and the preload and clear addresses read 0. An address with bits [1:0] not zero, or a word index of 7, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_tick | input | 1 | One-cycle pulse per slow-clock period, synchronous to clk |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Alarm interrupt request, level |

## Verification
A wrong prescaler phase shows up at the live-time register as a step that comes early or late. The reference model compares every cycle, so the mismatch appears on the first step edge, at most 2^PRESC_W ticks after the fault. A wrong Gray decode of a preload is visible at once on 0x18, in the cycle after the write. A wrong alarm match or clear priority shows up at `irq` and at 0x14 in the cycle after the step that should, or should not, have set the flag. Two instances, one per coding, run side by side on the same bus stimulus so that both encodings are exercised.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = 32;
    localparam int SEL_LSB  = 2;
    localparam int SEL_W    = 3;

    localparam int CTRL_ALM_BIT = 0;
    localparam int CTRL_RUN_BIT = 1;

    typedef enum logic [SEL_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_LOAD   = 3'd1,
        REG_ALARM  = 3'd2,
        REG_MASK   = 3'd3,
        REG_CLEAR  = 3'd4,
        REG_STATUS = 3'd5,
        REG_TIME   = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic alarm_on;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] v;
        v = g;
        for (int k = 0; k < $clog2(CNT_W); k++) begin
            v = v ^ (v >> (1 << k));
        end
        return v;
    endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
    parameter int PRESC_W = 15
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               tick,
    input  logic               restart,
    output logic               sec_pulse,
    output logic [PRESC_W-1:0] phase
);

    logic [PRESC_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run && tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign sec_pulse = run && tick && (phase_q == '1);
    assign phase     = phase_q;

    AST_IDLE_PHASE: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(phase_q)); // R2

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_sec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             advance,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    assign advance  = step && !load;
    assign cnt_next = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_next;
        end
    end

    assign cnt = cnt_q;

    AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(cnt_q)); // R2

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load && step) |=> (cnt_q == $past(load_val))); // R3

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_sec_pkg::*;
#(
    parameter bit GRAY_STORE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] alarm_wdata,
    input  logic             alarm_on,
    input  logic             advance,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             clr_req,
    output logic [CNT_W-1:0] alarm,
    output logic             status
);

    logic [CNT_W-1:0] alarm_q;
    logic [CNT_W-1:0] coded_next;
    logic             hit;
    logic             status_q;

    generate
        if (GRAY_STORE) begin : g_gray
            assign coded_next = bin_to_gray(cnt_next);
        end else begin : g_bin
            assign coded_next = cnt_next;
        end
    endgenerate

    assign hit = advance && alarm_on && (alarm_q != '0) && (coded_next == alarm_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q  <= '0;
            status_q <= 1'b0;
        end else begin
            if (alarm_wr) begin
                alarm_q <= alarm_wdata;
            end
            if (hit) begin
                status_q <= 1'b1;
            end else if (clr_req) begin
                status_q <= 1'b0;
            end
        end
    end

    assign alarm  = alarm_q;
    assign status = status_q;

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q) |-> ($past(alarm_q) != '0 && $past(alarm_on))); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !advance) |=> !status_q); // R7

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtc_sec_pkg::*;
#(
    parameter int PRESC_W    = 15,
    parameter bit GRAY_STORE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rtc_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    reg_sel_e           sel;
    logic               aligned;
    logic               wr_ctrl, wr_load, wr_alarm, wr_mask, wr_clear;
    ctrl_t              ctrl_q;
    logic               mask_q;
    logic [CNT_W-1:0]   load_val;
    logic               sec_pulse;
    logic [PRESC_W-1:0] phase;
    logic               advance;
    logic [CNT_W-1:0]   cnt_next;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   alarm;
    logic               status;

    assign sel     = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
    assign aligned = (bus_addr[SEL_LSB-1:0] == '0);

    assign wr_ctrl  = bus_wr && aligned && (sel == REG_CTRL);
    assign wr_load  = bus_wr && aligned && (sel == REG_LOAD);
    assign wr_alarm = bus_wr && aligned && (sel == REG_ALARM);
    assign wr_mask  = bus_wr && aligned && (sel == REG_MASK);
    assign wr_clear = bus_wr && aligned && (sel == REG_CLEAR) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= 1'b1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run      <= bus_wdata[CTRL_RUN_BIT];
                ctrl_q.alarm_on <= bus_wdata[CTRL_ALM_BIT];
            end
            if (wr_mask) begin
                mask_q <= bus_wdata[0];
            end
        end
    end

    generate
        if (GRAY_STORE) begin : g_load_gray
            assign load_val = gray_to_bin(bus_wdata);
        end else begin : g_load_bin
            assign load_val = bus_wdata;
        end
    endgenerate

    rtc_sec_prescaler #(.PRESC_W(PRESC_W)) i_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .tick      (rtc_tick),
        .restart   (wr_load),
        .sec_pulse (sec_pulse),
        .phase     (phase)
    );

    rtc_sec_counter i_count (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_load),
        .load_val (load_val),
        .step     (sec_pulse),
        .advance  (advance),
        .cnt_next (cnt_next),
        .cnt      (cnt)
    );

    rtc_sec_alarm #(.GRAY_STORE(GRAY_STORE)) i_alarm (
        .clk         (clk),
        .rst         (rst),
        .alarm_wr    (wr_alarm),
        .alarm_wdata (bus_wdata),
        .alarm_on    (ctrl_q.alarm_on),
        .advance     (advance),
        .cnt_next    (cnt_next),
        .clr_req     (wr_clear),
        .alarm       (alarm),
        .status      (status)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                REG_CTRL: begin
                    bus_rdata[CTRL_RUN_BIT] = ctrl_q.run;
                    bus_rdata[CTRL_ALM_BIT] = ctrl_q.alarm_on;
                end
                REG_ALARM:  bus_rdata = alarm;
                REG_MASK:   bus_rdata[0] = mask_q;
                REG_STATUS: bus_rdata[0] = status;
                REG_TIME:   bus_rdata = GRAY_STORE ? bin_to_gray(cnt) : cnt;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = status && !mask_q;

    AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (rst)
        wr_load |=> (phase == '0)); // R3

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($rose(status) || $fell(mask_q))); // R8

    AST_MASK_STILL_SETS: assert property (@(posedge clk) disable iff (rst)
        (mask_q && $rose(status)) |-> !irq); // R8

endmodule

// File: tb/test_rtc_seconds_core.sv
module test_rtc_seconds_core;

    localparam int CLK_PERIOD = 10;
    localparam int BENCH_PW   = 3;
    localparam int TICKS      = 1 << BENCH_PW;

    localparam logic [4:0] A_CTRL   = 5'h00;
    localparam logic [4:0] A_LOAD   = 5'h04;
    localparam logic [4:0] A_ALARM  = 5'h08;
    localparam logic [4:0] A_MASK   = 5'h0C;
    localparam logic [4:0] A_CLEAR  = 5'h10;
    localparam logic [4:0] A_STATUS = 5'h14;
    localparam logic [4:0] A_TIME   = 5'h18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rtc_tick = 1'b0;
    logic        tick_en = 1'b0;
    logic [4:0]  bus_addr = A_TIME;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata [2];
    logic        irq_o [2];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_seconds_core #(.PRESC_W(BENCH_PW), .GRAY_STORE(1'b0)) i_rtc_seconds_core (
        .clk(clk), .rst(rst), .rtc_tick(rtc_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .irq(irq_o[0]));

    rtc_seconds_core #(.PRESC_W(BENCH_PW), .GRAY_STORE(1'b1)) i_rtc_seconds_core_gray (
        .clk(clk), .rst(rst), .rtc_tick(rtc_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .irq(irq_o[1]));

    function automatic logic [31:0] enc(input int inst, input logic [31:0] b);
        return (inst == 1) ? (b ^ (b >> 1)) : b;
    endfunction

    function automatic logic [31:0] dec(input int inst, input logic [31:0] g);
        logic [31:0] b;
        if (inst == 0) return g;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // reference model state, one set per instance
    logic [31:0] m_cnt [2];
    logic [31:0] m_alarm [2];
    int          m_ph [2];
    bit          m_run [2], m_alen [2], m_mask [2], m_stat [2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            bit          setnow;
            bit          wok;
            logic [31:0] nc;
            setnow = 1'b0;
            wok = bus_wr && (bus_addr[1:0] == 2'b00);
            if (rst) begin
                m_cnt[i] = '0; m_alarm[i] = '0; m_ph[i] = 0;
                m_run[i] = 1'b0; m_alen[i] = 1'b0; m_mask[i] = 1'b1; m_stat[i] = 1'b0;
            end else begin
                if (wok && bus_addr == A_LOAD) begin
                    m_cnt[i] = dec(i, bus_wdata);
                    m_ph[i] = 0;
                end else if (m_run[i] && rtc_tick) begin
                    if (m_ph[i] == TICKS - 1) begin
                        m_ph[i] = 0;
                        nc = m_cnt[i] + 32'd1;
                        m_cnt[i] = nc;
                        if (m_alen[i] && m_alarm[i] != 0 && enc(i, nc) == m_alarm[i]) setnow = 1'b1;
                    end else begin
                        m_ph[i] = m_ph[i] + 1;
                    end
                end
                if (setnow) m_stat[i] = 1'b1;
                else if (wok && bus_addr == A_CLEAR && bus_wdata[0]) m_stat[i] = 1'b0;
                if (wok && bus_addr == A_CTRL) begin
                    m_run[i] = bus_wdata[1];
                    m_alen[i] = bus_wdata[0];
                end
                if (wok && bus_addr == A_ALARM) m_alarm[i] = bus_wdata;
                if (wok && bus_addr == A_MASK) m_mask[i] = bus_wdata[0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input int i, input logic [4:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a)
            A_CTRL:   return {30'd0, m_run[i], m_alen[i]};
            A_ALARM:  return m_alarm[i];
            A_MASK:   return {31'd0, m_mask[i]};
            A_STATUS: return {31'd0, m_stat[i]};
            A_TIME:   return enc(i, m_cnt[i]);
            default:  return '0;
        endcase
    endfunction

    function automatic string tag_for(input int i, input logic [4:0] a);
        if (a == A_TIME) return (i == 1) ? "R5" : "R4";
        if (a == A_STATUS) return "R6";
        if (a == A_ALARM && i == 1) return "R5";
        return "R9";
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!finished) begin
            for (int i = 0; i < 2; i++) begin
                check(tag_for(i, bus_addr), $sformatf("inst%0d read @%h", i, bus_addr),
                      rdata[i], exp_read(i, bus_addr));
                check("R8", $sformatf("inst%0d irq", i), {31'd0, irq_o[i]},
                      {31'd0, m_stat[i] && !m_mask[i]});
            end
        end
    end

    always @(negedge clk) rtc_tick <= tick_en;

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_TIME;
    endtask

    task automatic peek(input logic [4:0] a, input int i, input string tag, input logic [31:0] exp);
        bus_addr = a;
        #2;
        check(tag, $sformatf("directed inst%0d @%h", i, a), rdata[i], exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        peek(A_MASK, 0, "R1", 32'd1);
        peek(A_TIME, 0, "R1", 32'd0);
        peek(A_CTRL, 1, "R1", 32'd0);
        check("R1", "irq after reset", {31'd0, irq_o[0]}, 32'd0);

        // R2: ticks ignored while stopped
        tick_en = 1'b1;
        idle(3 * TICKS);
        peek(A_TIME, 0, "R2", 32'd0);

        // R3/R2: preload then count steps
        bus_write(A_CTRL, 32'h2);
        bus_write(A_LOAD, 32'd100);
        peek(A_TIME, 0, "R3", 32'd100);
        peek(A_TIME, 1, "R5", enc(1, dec(1, 32'd100)));
        idle(3 * TICKS);
        peek(A_TIME, 0, "R2", 32'd103);
        peek(A_TIME, 1, "R5", enc(1, dec(1, 32'd100) + 32'd3));

        // R6/R8: alarm with mask set, then unmask
        bus_write(A_ALARM, 32'd106);
        bus_write(A_CTRL, 32'h3);
        idle(5 * TICKS);
        peek(A_STATUS, 0, "R6", 32'd1);
        peek(A_STATUS, 1, "R6", 32'd1);
        check("R8", "masked irq", {31'd0, irq_o[0]}, 32'd0);
        bus_write(A_MASK, 32'hFFFF_FFFE);
        peek(A_MASK, 0, "R9", 32'd0);
        check("R8", "unmasked irq", {31'd0, irq_o[0]}, 32'd1);

        // R7: clear with bit0=0 ignored, bit0=1 clears
        bus_write(A_CLEAR, 32'hFFFF_FFFE);
        peek(A_STATUS, 0, "R7", 32'd1);
        bus_write(A_CLEAR, 32'h1);
        peek(A_STATUS, 0, "R7", 32'd0);
        check("R7", "irq after clear", {31'd0, irq_o[0]}, 32'd0);

        // R4/R6: wrap past all-ones with alarm word 0
        bus_write(A_ALARM, 32'd0);
        bus_write(A_LOAD, 32'hFFFF_FFFE);
        idle(3 * TICKS);
        peek(A_TIME, 0, "R4", 32'd1);
        peek(A_STATUS, 0, "R6", 32'd0);

        // R9: readback masking, misaligned and unused addresses
        bus_write(A_CTRL, 32'hFFFF_FFF2);
        peek(A_CTRL, 0, "R9", 32'd2);
        bus_write(5'h01, 32'h0);
        peek(A_CTRL, 0, "R9", 32'd2);
        peek(5'h1C, 0, "R9", 32'd0);
        peek(A_LOAD, 0, "R9", 32'd0);

        // R2: run off freezes count
        bus_write(A_CTRL, 32'h1);
        idle(4 * TICKS);
        peek(A_TIME, 0, "R2", 32'd1);

        // irregular ticks with preloads landing at varied phases
        bus_write(A_CTRL, 32'h3);
        bus_write(A_ALARM, 32'd7);
        for (int k = 0; k < 40; k++) begin
            tick_en = (k % 3) != 0;
            bus_write(A_LOAD, 32'd3 + (k % 2));
            idle(k % 11);
        end
        tick_en = 1'b1;
        idle(6 * TICKS);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule